// File: doc/BRIEF.md
# Round-Robin Dual Bus Switch

This block lets four on-chip memory requesters share two external memory buses. The four requesters are the main pipeline's instruction port (index 0), its data port (index 1), the shadow verifier's instruction port (index 2) and its data port (index 3). Each external bus has its own address, write-data, write-enable and read-data lines and talks to an asynchronous memory. The block therefore holds every transaction on its bus for a fixed number of cycles, taken from a configuration input, and does not wait for a handshake.

A requester pulses `req_i` for one cycle with its address, write enable and write data. The block latches the request and keeps that requester's stall high until the transaction has finished. Buses are handed out by a rotating priority pointer. If the requester whose turn it is has nothing pending, the next pending requester in rotation takes the bus in the same cycle. Read data is captured into a per-requester register on the last hold cycle. The stall drops in the following cycle, and the data stays on `req_rdata_o` until the next completed read from that requester.

Top module: `dual_bus_switch`

## Requirements
- R1: After reset every stall output and every bus valid output is low, and the rotation pointer starts at requester 0.
- R2: A request is latched in the cycle its `req_i` pulse is sampled. That requester's stall is high in the pulse cycle and stays high until completion. A pulse from a requester that already has a request outstanding is ignored, and no second transaction appears on either bus.
- R3: A latched request is granted no earlier than the cycle after it is latched. Free buses are filled in bus-index order (bus 0 first), each with the first eligible requester found by scanning upward from the pointer and wrapping.
- R4: The two buses never carry the same requester's transaction in the same cycle.
- R5: If the requester at the pointer has no eligible request, the bus goes in the same cycle to the next eligible requester in rotation (bus stealing).
- R6: A granted bus shows valid for exactly X consecutive cycles, where X is the wait-cycle input sampled at the grant. Address, write enable and write data stay unchanged throughout.
- R7: For a read, the bus read data is captured on the last hold cycle and the stall is low in the next cycle. A write drives write enable = 1 with the write data and leaves that requester's read-data register unchanged.
- R8: A wait-cycle value of 0 gives a hold of one cycle.
- R9: A bus in its last hold cycle can be granted again, so the next transaction is valid in the following cycle with no idle gap.
- R10: After a cycle with grants, the pointer moves to the requester just after the last one granted (bus 1's grant if both buses were granted). With no grant it stays where it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wait_cycles_i | input | WAITW | Hold length per transaction, 0 read as 1 |
| req_i | input | NREQ | One-cycle request pulse per requester |
| req_we_i | input | NREQ | Write enable per requester |
| req_addr_i | input | NREQ*AW | Address per requester, requester i at bits i*AW |
| req_wdata_i | input | NREQ*DW | Write data per requester |
| req_rdata_o | output | NREQ*DW | Last read data returned per requester |
| req_stall_o | output | NREQ | High while a request is outstanding |
| bus_valid_o | output | NBUS | Bus carries a transaction |
| bus_we_o | output | NBUS | Bus write enable |
| bus_addr_o | output | NBUS*AW | Bus address |
| bus_wdata_o | output | NBUS*DW | Bus write data |
| bus_rdata_i | input | NBUS*DW | Read data from memory per bus |

## Verification
Several properties are checked on every cycle. Both buses never carry the same owner at once. A grant goes only to a requester with a latched request and only to a free bus. A bus holds its address and data until its final cycle. A zero wait setting ends the hold after one cycle. A pending request stays pending until its bus completes. Other behaviours can only be seen across a scenario: the exact order of the rotation, bus stealing, back-to-back reuse of a bus, the hold length counted at the pins, the read data that comes back, and a repeated pulse being ignored. These are shown by the bench's reference model and its directed sequences.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  // Effective hold length: a programmed zero still occupies one cycle.
  function automatic int unsigned hold_len(input int unsigned w);
    return (w == 0) ? 1 : w;
  endfunction

  // First set bit of mask at or after start, wrapping within n; -1 if none.
  function automatic int rr_first(input logic [15:0] mask, input int start, input int n);
    int found;
    found = -1;
    for (int k = n - 1; k >= 0; k--) begin
      if (mask[(start + k) % n]) found = (start + k) % n;
    end
    return found;
  endfunction

  // Slot after idx in a ring of n.
  function automatic int ring_next(input int idx, input int n);
    return (idx + 1) % n;
  endfunction
endpackage

// File: rtl/dbs_req_slot.sv
module dbs_req_slot #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [AW-1:0] addr_in,
  input  logic          we_in,
  input  logic [DW-1:0] wdata_in,
  input  logic          done,
  input  logic [DW-1:0] bus_rdata,
  output logic          pend,
  output logic [AW-1:0] p_addr,
  output logic          p_we,
  output logic [DW-1:0] p_wdata,
  output logic [DW-1:0] rdata,
  output logic          stall
);
  logic accept;
  assign accept = req && !pend;
  assign stall  = pend || req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      p_addr  <= '0;
      p_we    <= 1'b0;
      p_wdata <= '0;
      rdata   <= '0;
    end else if (done) begin
      pend <= 1'b0;
      if (!p_we) rdata <= bus_rdata;
    end else if (accept) begin
      pend    <= 1'b1;
      p_addr  <= addr_in;
      p_we    <= we_in;
      p_wdata <= wdata_in;
    end
  end

  // R2: an outstanding request is kept until its completion
  a_r2_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !done |=> pend && stall);
endmodule

// File: rtl/dbs_rr_arbiter.sv
module dbs_rr_arbiter #(
  parameter int NREQ = 4,
  parameter int NBUS = 2,
  parameter int IW   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NREQ-1:0]    cand,
  input  logic [NBUS-1:0]    free,
  output logic [NBUS-1:0]    gnt_v,
  output logic [NBUS*IW-1:0] gnt_idx
);
  import dbs_pkg::*;

  logic [IW-1:0] ptr, ptr_nxt;

  always_comb begin
    logic [15:0] m;
    int s;
    int idx;
    m       = 16'(cand);
    s       = int'(ptr);
    gnt_v   = '0;
    gnt_idx = '0;
    for (int b = 0; b < NBUS; b++) begin
      idx = -1;
      if (free[b]) idx = rr_first(m, s, NREQ);
      if (idx >= 0) begin
        gnt_v[b]            = 1'b1;
        gnt_idx[b*IW +: IW] = IW'(idx);
        m[idx]              = 1'b0;
        s                   = ring_next(idx, NREQ);
      end
    end
    ptr_nxt = IW'(s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_nxt;
  end

  // R4: the two buses are never handed to one requester together
  a_r4_distinct_owners: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_v[0] && gnt_v[1] |-> gnt_idx[0 +: IW] != gnt_idx[IW +: IW]);
endmodule

// File: rtl/dbs_bus_lane.sv
module dbs_bus_lane #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int WAITW = 4,
  parameter int IW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WAITW-1:0] wait_cfg,
  input  logic             grant,
  input  logic [IW-1:0]    gidx,
  input  logic [AW-1:0]    gaddr,
  input  logic             gwe,
  input  logic [DW-1:0]    gwdata,
  output logic             busy,
  output logic             free,
  output logic             last,
  output logic [IW-1:0]    owner,
  output logic [AW-1:0]    addr,
  output logic             we,
  output logic [DW-1:0]    wdata
);
  import dbs_pkg::*;

  logic [WAITW-1:0] cnt;

  assign last = busy && (cnt == WAITW'(1));
  assign free = !busy || last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      owner <= '0;
      addr  <= '0;
      we    <= 1'b0;
      wdata <= '0;
    end else if (grant) begin
      busy  <= 1'b1;
      cnt   <= WAITW'(hold_len(int'(wait_cfg)));
      owner <= gidx;
      addr  <= gaddr;
      we    <= gwe;
      wdata <= gwdata;
    end else if (last) begin
      busy <= 1'b0;
    end else if (busy) begin
      cnt <= cnt - WAITW'(1);
    end
  end

  // R6: a transaction keeps its bus and its fields until the final cycle
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !last |=> busy && $stable(addr) && $stable(we) && $stable(wdata) && $stable(owner));
  // R8: a zero wait setting ends the hold after one cycle
  a_r8_zero_is_one: assert property (@(posedge clk) disable iff (!rst_n)
    grant && wait_cfg == '0 |=> last);
endmodule

// File: rtl/dual_bus_switch.sv
module dual_bus_switch #(
  parameter int NREQ  = 4,
  parameter int NBUS  = 2,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int WAITW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WAITW-1:0]   wait_cycles_i,
  input  logic [NREQ-1:0]    req_i,
  input  logic [NREQ-1:0]    req_we_i,
  input  logic [NREQ*AW-1:0] req_addr_i,
  input  logic [NREQ*DW-1:0] req_wdata_i,
  output logic [NREQ*DW-1:0] req_rdata_o,
  output logic [NREQ-1:0]    req_stall_o,
  output logic [NBUS-1:0]    bus_valid_o,
  output logic [NBUS-1:0]    bus_we_o,
  output logic [NBUS*AW-1:0] bus_addr_o,
  output logic [NBUS*DW-1:0] bus_wdata_o,
  input  logic [NBUS*DW-1:0] bus_rdata_i
);
  localparam int IW = (NREQ > 1) ? $clog2(NREQ) : 1;

  logic [NREQ-1:0]    pend, onbus, done, cand;
  logic [AW-1:0]      p_addr  [NREQ];
  logic               p_we    [NREQ];
  logic [DW-1:0]      p_wdata [NREQ];
  logic [DW-1:0]      rd_sel  [NREQ];
  logic [NBUS-1:0]    busy, free, last, gnt_v;
  logic [IW-1:0]      owner   [NBUS];
  logic [NBUS*IW-1:0] gnt_idx;

  // Which requesters sit on a bus, which finish now, and their read data.
  always_comb begin
    onbus = '0;
    done  = '0;
    for (int i = 0; i < NREQ; i++) rd_sel[i] = '0;
    for (int b = 0; b < NBUS; b++) begin
      if (busy[b]) onbus[owner[b]] = 1'b1;
      if (last[b]) begin
        done[owner[b]]   = 1'b1;
        rd_sel[owner[b]] = bus_rdata_i[b*DW +: DW];
      end
    end
  end

  assign cand = pend & ~onbus;

  for (genvar i = 0; i < NREQ; i++) begin : g_slot
    dbs_req_slot #(.AW(AW), .DW(DW)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req_i[i]),
      .addr_in   (req_addr_i[i*AW +: AW]),
      .we_in     (req_we_i[i]),
      .wdata_in  (req_wdata_i[i*DW +: DW]),
      .done      (done[i]),
      .bus_rdata (rd_sel[i]),
      .pend      (pend[i]),
      .p_addr    (p_addr[i]),
      .p_we      (p_we[i]),
      .p_wdata   (p_wdata[i]),
      .rdata     (req_rdata_o[i*DW +: DW]),
      .stall     (req_stall_o[i])
    );
  end

  dbs_rr_arbiter #(.NREQ(NREQ), .NBUS(NBUS), .IW(IW)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .cand    (cand),
    .free    (free),
    .gnt_v   (gnt_v),
    .gnt_idx (gnt_idx)
  );

  for (genvar b = 0; b < NBUS; b++) begin : g_lane
    logic [IW-1:0] gi;
    assign gi = gnt_idx[b*IW +: IW];

    dbs_bus_lane #(.AW(AW), .DW(DW), .WAITW(WAITW), .IW(IW)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .wait_cfg (wait_cycles_i),
      .grant    (gnt_v[b]),
      .gidx     (gi),
      .gaddr    (p_addr[gi]),
      .gwe      (p_we[gi]),
      .gwdata   (p_wdata[gi]),
      .busy     (busy[b]),
      .free     (free[b]),
      .last     (last[b]),
      .owner    (owner[b]),
      .addr     (bus_addr_o[b*AW +: AW]),
      .we       (bus_we_o[b]),
      .wdata    (bus_wdata_o[b*DW +: DW])
    );

    // R3: only a latched, not yet served request may be granted
    a_r3_grant_pending: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_v[b] |-> pend[gi] && !onbus[gi]);
    // R9: a grant lands only on a bus that is idle or in its last cycle
    a_r9_grant_free_bus: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_v[b] |-> !busy[b] || last[b]);
  end

  assign bus_valid_o = busy;
endmodule

// File: tb/dual_bus_switch_test.sv
module dual_bus_switch_test;
  localparam int NREQ = 4, NBUS = 2, AW = 16, DW = 32, WAITW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic               rst_n = 1'b0;
  logic [WAITW-1:0]   wcfg  = '0;
  logic [NREQ-1:0]    req   = '0;
  logic [NREQ-1:0]    wen   = '0;
  logic [NREQ*AW-1:0] addr  = '0;
  logic [NREQ*DW-1:0] wdat  = '0;
  logic [NREQ*DW-1:0] rdat;
  logic [NREQ-1:0]    stall;
  logic [NBUS-1:0]    bval, bwe;
  logic [NBUS*AW-1:0] baddr;
  logic [NBUS*DW-1:0] bwd, brd;

  // Memory returns {address, inverted address}.
  always_comb
    for (int b = 0; b < NBUS; b++)
      brd[b*DW +: DW] = {baddr[b*AW +: AW], ~baddr[b*AW +: AW]};

  dual_bus_switch #(.NREQ(NREQ), .NBUS(NBUS), .AW(AW), .DW(DW), .WAITW(WAITW)) uut (
    .clk(clk), .rst_n(rst_n), .wait_cycles_i(wcfg), .req_i(req), .req_we_i(wen),
    .req_addr_i(addr), .req_wdata_i(wdat), .req_rdata_o(rdat), .req_stall_o(stall),
    .bus_valid_o(bval), .bus_we_o(bwe), .bus_addr_o(baddr), .bus_wdata_o(bwd),
    .bus_rdata_i(brd)
  );

  int errors = 0, checks = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_pend [NREQ];
  logic [AW-1:0] m_addr [NREQ];
  logic        m_we   [NREQ];
  logic [DW-1:0] m_wd [NREQ];
  logic [DW-1:0] m_rd [NREQ];
  int m_busy [NBUS], m_left [NBUS], m_own [NBUS];
  int m_ptr;
  int pre_p [NREQ], taken [NREQ], g [NBUS], fin [NBUS], frb [NBUS];
  int start;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREQ; i++) begin
        m_pend[i] = 0; m_addr[i] = '0; m_we[i] = 1'b0; m_wd[i] = '0; m_rd[i] = '0;
      end
      for (int b = 0; b < NBUS; b++) begin m_busy[b] = 0; m_left[b] = 0; m_own[b] = 0; end
      m_ptr = 0;
    end else begin
      for (int i = 0; i < NREQ; i++) begin pre_p[i] = m_pend[i]; taken[i] = 0; end
      for (int b = 0; b < NBUS; b++) begin
        fin[b] = (m_busy[b] != 0 && m_left[b] == 1) ? 1 : 0;
        frb[b] = (m_busy[b] == 0 || m_left[b] == 1) ? 1 : 0;
        if (m_busy[b] != 0) taken[m_own[b]] = 1;
      end
      start = m_ptr;
      for (int b = 0; b < NBUS; b++) begin
        g[b] = -1;
        if (frb[b] != 0)
          for (int k = 0; k < NREQ; k++)
            if (g[b] < 0 && pre_p[(start + k) % NREQ] != 0 && taken[(start + k) % NREQ] == 0)
              g[b] = (start + k) % NREQ;
        if (g[b] >= 0) begin taken[g[b]] = 1; start = g[b] + 1; end
      end
      m_ptr = start % NREQ;
      for (int b = 0; b < NBUS; b++) begin
        if (fin[b] != 0) begin
          m_pend[m_own[b]] = 0;
          if (!m_we[m_own[b]]) m_rd[m_own[b]] = {m_addr[m_own[b]], ~m_addr[m_own[b]]};
          m_busy[b] = 0;
        end else if (m_busy[b] != 0) m_left[b]--;
        if (g[b] >= 0) begin
          m_busy[b] = 1; m_own[b] = g[b];
          m_left[b] = (wcfg == 0) ? 1 : int'(wcfg);
        end
      end
      for (int i = 0; i < NREQ; i++)
        if (req[i] && pre_p[i] == 0) begin
          m_pend[i] = 1; m_addr[i] = addr[i*AW +: AW];
          m_we[i] = wen[i]; m_wd[i] = wdat[i*DW +: DW];
        end
    end
  end

  // Compare every cycle, away from the edge.
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < NREQ; i++) begin
        chk("R2 stall", 64'(stall[i]), 64'((m_pend[i] != 0) || req[i]));
        chk("R7 rdata", 64'(rdat[i*DW +: DW]), 64'(m_rd[i]));
      end
      for (int b = 0; b < NBUS; b++) begin
        chk("R6 valid", 64'(bval[b]), 64'(m_busy[b] != 0));
        if (m_busy[b] != 0) begin
          chk("R3/R5/R10 owner addr", 64'(baddr[b*AW +: AW]), 64'(m_addr[m_own[b]]));
          chk("R6 we", 64'(bwe[b]), 64'(m_we[m_own[b]]));
          chk("R6 wdata", 64'(bwd[b*DW +: DW]), 64'(m_wd[m_own[b]]));
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic put(input int i, input logic [AW-1:0] a, input logic w, input logic [DW-1:0] d);
    req[i] = 1'b1; addr[i*AW +: AW] = a; wen[i] = w; wdat[i*DW +: DW] = d;
  endtask

  task automatic pulse();
    @(posedge clk); @(negedge clk); #1 req = '0;
  endtask

  task automatic drain();
    for (int k = 0; k < 60 && stall != '0; k++) begin @(negedge clk); #1; end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finished");
    summary();
  end

  int n;

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 stall after reset", 64'(stall), 64'(0));
    chk("R1 bus idle after reset", 64'(bval), 64'(0));
    #1;

    // Single read, X = 3 (pointer 0 -> bus 0 gets requester 0).
    wcfg = 4'd3; put(0, 16'h0A10, 1'b0, '0); pulse();
    n = 0;
    for (int k = 0; k < 40 && stall[0]; k++) begin @(negedge clk); if (bval[0]) n++; end
    chk("R6 hold length X=3", 64'(n), 64'(3));
    chk("R7 read data", 64'(rdat[0 +: DW]), 64'({16'h0A10, ~16'h0A10}));
    #1;

    // Zero wait -> one cycle; pointer now 1.
    wcfg = 4'd0; put(1, 16'h1B20, 1'b0, '0); pulse();
    n = 0;
    for (int k = 0; k < 40 && stall[1]; k++) begin @(negedge clk); if (bval[0]) n++; end
    chk("R8 zero wait is one cycle", 64'(n), 64'(1));
    #1;

    // All four at once, X = 2; pointer is 2.
    wcfg = 4'd2;
    for (int i = 0; i < NREQ; i++) put(i, 16'(i * 16'h1000 + 16'h0C00), 1'b0, '0);
    pulse();
    @(negedge clk);
    chk("R3 bus0 takes pointer requester", 64'(baddr[0 +: AW]), 64'(16'h2C00));
    chk("R3 bus1 takes next requester", 64'(baddr[AW +: AW]), 64'(16'h3C00));
    chk("R4 distinct owners", 64'(baddr[0 +: AW] != baddr[AW +: AW]), 64'(1));
    @(negedge clk); @(negedge clk);
    chk("R9 bus0 reused without gap", 64'({bval[0], baddr[0 +: AW]}), 64'({1'b1, 16'h0C00}));
    chk("R10 wrapped to requester 1", 64'({bval[1], baddr[AW +: AW]}), 64'({1'b1, 16'h1C00}));
    #1 drain();

    // Steal: pointer is 2, only requester 0 asks.
    put(0, 16'h0E40, 1'b0, '0); pulse();
    @(negedge clk);
    chk("R5 idle turn stolen", 64'({bval[0], baddr[0 +: AW]}), 64'({1'b1, 16'h0E40}));
    #1 drain();

    // Write from requester 3.
    wcfg = 4'd1; put(3, 16'h3C30, 1'b1, 32'hDEADBEEF); pulse();
    @(negedge clk);
    chk("R7 write drive", 64'({bval[0], bwe[0], bwd[0 +: DW]}), 64'({1'b1, 1'b1, 32'hDEADBEEF}));
    #1 drain();
    chk("R7 write keeps rdata", 64'(rdat[3*DW +: DW]), 64'({16'h3C00, ~16'h3C00}));

    // Repeated pulse while pending is ignored.
    wcfg = 4'd4; put(2, 16'h2D00, 1'b0, '0); pulse();
    put(2, 16'h2EEE, 1'b0, '0); pulse();
    chk("R2 first address kept", 64'(baddr[0 +: AW]), 64'(16'h2D00));
    drain();
    repeat (3) begin
      @(negedge clk);
      chk("R2 no second transaction", 64'({bval, stall}), 64'(0));
    end
    #1;

    // Random traffic against the model.
    for (int c = 0; c < 3000; c++) begin
      if (c % 37 == 0) wcfg = WAITW'($urandom_range(0, 5));
      for (int i = 0; i < NREQ; i++)
        if ($urandom_range(0, 3) == 0)
          put(i, {i[1:0], 14'($urandom)}, 1'($urandom), $urandom);
      @(posedge clk); @(negedge clk); #1 req = '0;
    end
    drain();
    summary();
  end
endmodule